// File: doc/BRIEF.md
# Compare Bank with Sync Pulse Generator

This block watches a free-running 64-bit time counter supplied from outside and compares it against a bank of programmable 64-bit thresholds. Each enabled comparator raises a one-cycle event the first cycle the counter is at or above its threshold and latches a sticky status bit that software clears by writing 1. Comparator 0 can request a counter reset, so the external time base is folded into a fixed-length cycle. In shadow mode, threshold writes are held in a staging copy and take effect only at that cycle boundary.

Comparator 1 triggers the sync generator. This state machine drives one output pulse of programmable width. It can wait a programmable number of cycles before the first rising edge. With a zero period it issues one pulse per trigger. With a nonzero period it repeats the pulse until sync is switched off. Its states are IDLE (waiting for a trigger), DELAY (counting the start delay), HIGH (output asserted for the width) and LOW (the rest of a period). The transitions are:

- IDLE to DELAY: trigger with a nonzero start value.
- IDLE to HIGH: trigger with a zero start value.
- DELAY to HIGH: the delay is used up.
- HIGH to IDLE: the width is used up and the period is zero.
- HIGH to LOW: the width is used up and the period is larger than the width.
- HIGH to HIGH: the width is used up and the period is nonzero but no larger than the width.
- LOW to HIGH: the rest of the period is used up.
- Any state to IDLE: sync is disabled.

Top module: `cmp_sync_gen`

## Requirements
- R1: An enabled comparator n (enable in configuration bit n+1, address 0x070) raises cmp_evt_o[n] for exactly the first cycle in which time_cnt_i is greater than or equal to its 64-bit threshold. The threshold's low word sits at 0x078+8n and its high word at 0x07C+8n. The event fires combinationally in the cycle the counter input meets the threshold.
- R2: Status bit n (address 0x074) sets on the clock edge that ends an event cycle of comparator n. It stays set until a write of 1 to bit n clears it. It does not set again while the counter stays at or above the threshold.
- R3: A comparator whose enable bit is 0 produces no event and no status, whatever the counter value.
- R4: When configuration bit 0 is set, cnt_rst_o is high in exactly the cycles where cmp_evt_o[0] is high; with bit 0 clear it stays low.
- R5: With configuration bit 17 clear, a threshold write is read back from its address in the next cycle. With bit 17 set, the write is staged, the read-back keeps the old value, and the staged value becomes active on the edge that ends a cnt_rst_o cycle.
- R6: The sync output runs only while bits 0 and 1 of the sync control word (0x180) are both 1. Any other value returns the generator to IDLE at the next edge, and a trigger arriving then is ignored.
- R7: With period (0x194) equal to 0 and start (0x19C) equal to 0, a comparator-1 event in IDLE makes sync0_o high from the next cycle for `width` cycles (0x190; a width of 0 counts as 1). The output then stays low until a new event.
- R8: With a nonzero period P greater than the width, rising edges repeat every P cycles. With 0 < P not greater than the width, the output stays high continuously.
- R9: A nonzero start value S delays the first rising edge by S cycles relative to R7.
- R10: The sync status bit (0x188 bit 0) sets on the edge where the output enters HIGH and is cleared by writing 1.
- R11: After reset, all registers read 0, sync0_o and cnt_rst_o are low, and an unmapped address reads 0.
- R12: Width, period and start registers read back the value written at their addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| time_cnt_i | input | 64 | External time counter |
| cnt_rst_o | output | 1 | Counter reset request from comparator 0 |
| cmp_evt_o | output | NUM_CMP | Per-comparator match events |
| sync0_o | output | 1 | Sync pulse output |

## Verification
The checker watches these properties on every cycle:
- A status bit drops only after a clear write.
- A reset request is always followed by comparator-0 status.
- Shadowed thresholds hold between reset requests.
- A disabled generator drives its output low.
- Every rising sync edge comes with the sync status bit.

Only the bench's scenarios can show the following:
- Event timing relative to random thresholds.
- Pulse widths and periods.
- The start delay.
- The continuous-high corner.
- The deferred read-back in shadow mode.

// File: rtl/cmp_sync_pkg.sv
package cmp_sync_pkg;

    localparam int unsigned ADDR_W = 10;
    localparam int unsigned WORD_W = 32;

    localparam logic [ADDR_W-1:0] A_CFG      = 10'h070;
    localparam logic [ADDR_W-1:0] A_STAT     = 10'h074;
    localparam logic [ADDR_W-1:0] A_CMP_BASE = 10'h078;
    localparam logic [ADDR_W-1:0] A_SCTRL    = 10'h180;
    localparam logic [ADDR_W-1:0] A_SSTAT    = 10'h188;
    localparam logic [ADDR_W-1:0] A_SWIDTH   = 10'h190;
    localparam logic [ADDR_W-1:0] A_SPERIOD  = 10'h194;
    localparam logic [ADDR_W-1:0] A_SSTART   = 10'h19C;

    localparam int unsigned CFG_W      = 18;
    localparam int unsigned RST_BIT    = 0;
    localparam int unsigned SHADOW_BIT = 17;

    typedef enum logic [1:0] {
        SY_IDLE,
        SY_DELAY,
        SY_HIGH,
        SY_LOW
    } sync_state_e;

    function automatic logic [ADDR_W-1:0] cmp_addr(input int unsigned idx, input logic hi);
        return A_CMP_BASE + ADDR_W'(idx * 8) + (hi ? ADDR_W'(4) : ADDR_W'(0));
    endfunction

endpackage

// File: rtl/cmp_slot.sv
module cmp_slot #(
    parameter int unsigned VAL_W  = 64,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              shadow_en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wdata,
    input  logic              reload,
    input  logic [VAL_W-1:0]  count,
    output logic [VAL_W-1:0]  active_o,
    output logic              event_o
);

    localparam int unsigned HI_W = VAL_W - WORD_W;

    logic [VAL_W-1:0] active_q, active_d;
    logic [VAL_W-1:0] staged_q, staged_d;
    logic             hit, hit_q;

    function automatic logic [VAL_W-1:0] merge(input logic [VAL_W-1:0] base);
        logic [VAL_W-1:0] r;
        r = base;
        if (wr_lo) r[WORD_W-1:0] = wdata;
        if (wr_hi) r[VAL_W-1:WORD_W] = wdata[HI_W-1:0];
        return r;
    endfunction

    always_comb begin
        if (shadow_en) begin
            staged_d = merge(staged_q);
            active_d = reload ? staged_d : active_q;
        end else begin
            active_d = merge(active_q);
            staged_d = active_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            staged_q <= '0;
            hit_q    <= 1'b0;
        end else begin
            active_q <= active_d;
            staged_q <= staged_d;
            hit_q    <= hit;
        end
    end

    assign hit      = enable && (count >= active_q);
    assign event_o  = hit && !hit_q;
    assign active_o = active_q;

endmodule

// File: rtl/sync_pulse_fsm.sv
module sync_pulse_fsm
    import cmp_sync_pkg::*;
#(
    parameter int unsigned TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          trigger,
    input  logic [TW-1:0] width,
    input  logic [TW-1:0] period,
    input  logic [TW-1:0] start,
    output logic          pulse_o,
    output logic          issue_o
);

    sync_state_e   state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic [TW-1:0] w_eff;

    assign w_eff = (width == '0) ? TW'(1) : width;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        issue_o = 1'b0;
        if (!enable) begin
            state_d = SY_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                SY_IDLE: begin
                    if (trigger) begin
                        if (start != '0) begin
                            state_d = SY_DELAY;
                            cnt_d   = start - TW'(1);
                        end else begin
                            state_d = SY_HIGH;
                            cnt_d   = w_eff - TW'(1);
                            issue_o = 1'b1;
                        end
                    end
                end
                SY_DELAY: begin
                    if (cnt_q == '0) begin
                        state_d = SY_HIGH;
                        cnt_d   = w_eff - TW'(1);
                        issue_o = 1'b1;
                    end else begin
                        cnt_d = cnt_q - TW'(1);
                    end
                end
                SY_HIGH: begin
                    if (cnt_q != '0) begin
                        cnt_d = cnt_q - TW'(1);
                    end else if (period == '0) begin
                        state_d = SY_IDLE;
                    end else if (period > w_eff) begin
                        state_d = SY_LOW;
                        cnt_d   = period - w_eff - TW'(1);
                    end else begin
                        state_d = SY_HIGH;
                        cnt_d   = w_eff - TW'(1);
                        issue_o = 1'b1;
                    end
                end
                SY_LOW: begin
                    if (cnt_q == '0) begin
                        state_d = SY_HIGH;
                        cnt_d   = w_eff - TW'(1);
                        issue_o = 1'b1;
                    end else begin
                        cnt_d = cnt_q - TW'(1);
                    end
                end
                default: begin
                    state_d = SY_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SY_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        pulse_o = (state_q == SY_HIGH);
    end

endmodule

// File: rtl/cmp_sync_gen.sv
module cmp_sync_gen
    import cmp_sync_pkg::*;
#(
    parameter int unsigned NUM_CMP = 4,
    parameter int unsigned VAL_W   = 64,
    parameter int unsigned TMR_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [9:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [VAL_W-1:0]   time_cnt_i,
    output logic               cnt_rst_o,
    output logic [NUM_CMP-1:0] cmp_evt_o,
    output logic               sync0_o
);

    localparam int unsigned HI_W = VAL_W - WORD_W;

    logic [CFG_W-1:0]   cfg_q;
    logic [NUM_CMP-1:0] stat_q;
    logic [1:0]         sctrl_q;
    logic               sstat_q;
    logic [TMR_W-1:0]   width_q, period_q, start_q;

    logic [VAL_W-1:0]   act [NUM_CMP];
    logic [NUM_CMP-1:0] evt;
    logic               sync_on, issue;
    logic [NUM_CMP-1:0] stat_clr;
    logic               sstat_clr;

    function automatic logic wr_at(input logic [ADDR_W-1:0] a);
        return reg_we && (reg_addr == a);
    endfunction

    generate
        for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
            cmp_slot #(.VAL_W(VAL_W), .WORD_W(WORD_W)) u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .enable   (cfg_q[i+1]),
                .shadow_en(cfg_q[SHADOW_BIT]),
                .wr_lo    (wr_at(cmp_addr(i, 1'b0))),
                .wr_hi    (wr_at(cmp_addr(i, 1'b1))),
                .wdata    (reg_wdata),
                .reload   (cnt_rst_o),
                .count    (time_cnt_i),
                .active_o (act[i]),
                .event_o  (evt[i])
            );
        end
    endgenerate

    assign cmp_evt_o = evt;
    assign cnt_rst_o = evt[0] && cfg_q[RST_BIT];
    assign sync_on   = sctrl_q[0] && sctrl_q[1];
    assign stat_clr  = wr_at(A_STAT) ? reg_wdata[NUM_CMP-1:0] : '0;
    assign sstat_clr = wr_at(A_SSTAT) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            stat_q   <= '0;
            sctrl_q  <= '0;
            sstat_q  <= 1'b0;
            width_q  <= '0;
            period_q <= '0;
            start_q  <= '0;
        end else begin
            if (wr_at(A_CFG))     cfg_q    <= reg_wdata[CFG_W-1:0];
            if (wr_at(A_SCTRL))   sctrl_q  <= reg_wdata[1:0];
            if (wr_at(A_SWIDTH))  width_q  <= reg_wdata[TMR_W-1:0];
            if (wr_at(A_SPERIOD)) period_q <= reg_wdata[TMR_W-1:0];
            if (wr_at(A_SSTART))  start_q  <= reg_wdata[TMR_W-1:0];
            stat_q  <= (stat_q & ~stat_clr) | evt;
            sstat_q <= (sstat_q && !sstat_clr) || issue;
        end
    end

    sync_pulse_fsm #(.TW(TMR_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (sync_on),
        .trigger(evt[1]),
        .width  (width_q),
        .period (period_q),
        .start  (start_q),
        .pulse_o(sync0_o),
        .issue_o(issue)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CFG)     reg_rdata = 32'(cfg_q);
        if (reg_addr == A_STAT)    reg_rdata = 32'(stat_q);
        if (reg_addr == A_SCTRL)   reg_rdata = 32'(sctrl_q);
        if (reg_addr == A_SSTAT)   reg_rdata = 32'(sstat_q);
        if (reg_addr == A_SWIDTH)  reg_rdata = 32'(width_q);
        if (reg_addr == A_SPERIOD) reg_rdata = 32'(period_q);
        if (reg_addr == A_SSTART)  reg_rdata = 32'(start_q);
        for (int i = 0; i < NUM_CMP; i++) begin
            if (reg_addr == cmp_addr(i, 1'b0)) reg_rdata = act[i][WORD_W-1:0];
            if (reg_addr == cmp_addr(i, 1'b1)) reg_rdata = 32'(act[i][VAL_W-1:WORD_W]);
        end
    end

endmodule

// File: rtl/cmp_sync_chk.sv
module cmp_sync_chk
    import cmp_sync_pkg::*;
#(
    parameter int unsigned VAL_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [9:0]       reg_addr,
    input logic             clr0,
    input logic             stat0,
    input logic             cnt_rst_o,
    input logic             shadow_on,
    input logic [VAL_W-1:0] act0,
    input logic             sync_on,
    input logic             sync_stat,
    input logic             sync0_o
);

    // R2
    stat_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat0) |-> $past(reg_we && reg_addr == A_STAT && clr0));

    // R4
    rst_req_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst_o |=> stat0);

    // R5
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow_on && !cnt_rst_o) |=> $stable(act0));

    // R6
    sync_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_on |=> !sync0_o);

    // R10
    sync_rise_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync0_o) |-> sync_stat);

endmodule

bind cmp_sync_gen cmp_sync_chk #(.VAL_W(VAL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .clr0     (reg_wdata[0]),
    .stat0    (stat_q[0]),
    .cnt_rst_o(cnt_rst_o),
    .shadow_on(cfg_q[17]),
    .act0     (act[0]),
    .sync_on  (sync_on),
    .sync_stat(sstat_q),
    .sync0_o  (sync0_o)
);

// File: tb/cmp_sync_gen_tb.sv
module cmp_sync_gen_tb;

    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] time_cnt = '0;
    logic        cnt_rst_o;
    logic [NC-1:0] cmp_evt_o;
    logic        sync0_o;

    int checks = 0;
    int errors = 0;
    int r_highs, r_rises, r_first;
    logic [31:0] rv;

    always #4 clk = ~clk;

    cmp_sync_gen #(.NUM_CMP(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_cnt_i(time_cnt),
        .cnt_rst_o(cnt_rst_o), .cmp_evt_o(cmp_evt_o), .sync0_o(sync0_o)
    );

    function automatic logic [9:0] lo_addr(int i);
        return 10'h078 + 10'(8 * i);
    endfunction

    function automatic logic exp_hit(logic [63:0] cnt, logic [63:0] thr);
        return cnt >= thr;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [9:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_cnt(logic [63:0] c);
        time_cnt = c;
        #1;
    endtask

    task automatic run_cycles(int n);
        logic prev;
        prev = sync0_o;
        r_highs = 0; r_rises = 0; r_first = 0;
        for (int k = 1; k <= n; k++) begin
            tick();
            #1;
            if (sync0_o) r_highs++;
            if (sync0_o && !prev) begin
                r_rises++;
                if (r_first == 0) r_first = k;
            end
            prev = sync0_o;
        end
    endtask

    // arm comparator 1 at threshold 50, configure sync, then trigger
    task automatic sync_run(logic [1:0] ctrl, int w, int p, int s, int n);
        set_cnt(64'd0);
        wr(10'h070, 32'h4);
        wr(lo_addr(1), 32'd50);
        wr(lo_addr(1) + 10'd4, 32'd0);
        wr(10'h190, 32'(w));
        wr(10'h194, 32'(p));
        wr(10'h19C, 32'(s));
        wr(10'h188, 32'h1);
        wr(10'h180, 32'(ctrl));
        set_cnt(64'd50);
        run_cycles(n);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R11 reset state
        rd(10'h070, rv); chk("R11 cfg", rv, 0);
        rd(10'h074, rv); chk("R11 stat", rv, 0);
        rd(10'h180, rv); chk("R11 sctrl", rv, 0);
        rd(10'h100, rv); chk("R11 unmapped", rv, 0);
        chk("R11 sync0", sync0_o, 0);
        chk("R11 cnt_rst", cnt_rst_o, 0);

        // R12 register readback
        wr(10'h190, 32'h1234); rd(10'h190, rv); chk("R12 width", rv, 32'h1234);
        wr(10'h194, 32'h55AA); rd(10'h194, rv); chk("R12 period", rv, 32'h55AA);
        wr(10'h19C, 32'h0F0F); rd(10'h19C, rv); chk("R12 start", rv, 32'h0F0F);

        // R1 / R2 random thresholds
        for (int it = 0; it < 24; it++) begin
            int i;
            logic [63:0] v, c;
            i = int'($urandom % NC);
            v = {$urandom, $urandom};
            v[63] = 1'b0;
            if (v < 64'd8) v = 64'd8;
            set_cnt(64'd0);
            wr(10'h070, 32'(1) << (i + 1));
            wr(lo_addr(i), v[31:0]);
            wr(lo_addr(i) + 10'd4, v[63:32]);
            wr(10'h074, 32'hF);
            rd(lo_addr(i) + 10'd4, rv); chk("R1 thr hi readback", rv, v[63:32]);
            c = v - 64'd1;
            set_cnt(c);
            chk("R1 below", cmp_evt_o, exp_hit(c, v) ? (NC'(1) << i) : '0);
            tick();
            set_cnt(v);
            chk("R1 at threshold", cmp_evt_o, NC'(1) << i);
            tick();
            c = v + 64'($urandom % 100);
            set_cnt(c);
            chk("R1 single cycle", cmp_evt_o, '0);
            rd(10'h074, rv); chk("R2 status set", rv, 32'(1) << i);
        end

        // R2 clear while still above threshold: stays clear
        set_cnt(64'd0);
        wr(10'h070, 32'h10);
        wr(lo_addr(3), 32'd30);
        wr(lo_addr(3) + 10'd4, 32'd0);
        wr(10'h074, 32'hF);
        set_cnt(64'd40);
        tick();
        rd(10'h074, rv); chk("R2 set", rv, 32'h8);
        wr(10'h074, 32'h8);
        repeat (3) tick();
        rd(10'h074, rv); chk("R2 once", rv, 32'h0);

        // R3 disabled comparator
        set_cnt(64'd0);
        wr(10'h070, 32'h0);
        wr(lo_addr(2), 32'd10);
        set_cnt(64'd20);
        chk("R3 no event", cmp_evt_o, '0);
        tick();
        rd(10'h074, rv); chk("R3 no status", rv, 0);

        // R4 counter reset request
        set_cnt(64'd0);
        wr(10'h070, 32'h3);
        wr(lo_addr(0), 32'd100);
        wr(lo_addr(0) + 10'd4, 32'd0);
        set_cnt(64'd99);  chk("R4 below", cnt_rst_o, 0);
        tick();
        set_cnt(64'd100); chk("R4 fire", cnt_rst_o, 1);
        tick();
        set_cnt(64'd101); chk("R4 one cycle", cnt_rst_o, 0);
        set_cnt(64'd0);
        wr(10'h070, 32'h2);
        set_cnt(64'd100);
        chk("R4 off no req", cnt_rst_o, 0);
        chk("R4 off event", cmp_evt_o[0], 1);
        tick();

        // R5 shadow mode
        set_cnt(64'd0);
        wr(10'h070, 32'h3);
        wr(lo_addr(0), 32'd77);
        rd(lo_addr(0), rv); chk("R5 direct write", rv, 77);
        wr(lo_addr(0), 32'd100);
        wr(10'h070, (32'h1 << 17) | 32'h3);
        wr(lo_addr(0), 32'd200);
        rd(lo_addr(0), rv); chk("R5 deferred", rv, 100);
        set_cnt(64'd100);
        chk("R5 boundary", cnt_rst_o, 1);
        tick();
        rd(lo_addr(0), rv); chk("R5 applied", rv, 200);
        set_cnt(64'd0);
        wr(10'h070, 32'h0);

        // R7 one-shot
        sync_run(2'b11, 3, 0, 0, 15);
        chk("R7 highs", r_highs, 3);
        chk("R7 rises", r_rises, 1);
        chk("R7 first", r_first, 1);
        rd(10'h188, rv); chk("R10 status set", rv, 1);
        wr(10'h188, 32'h1);
        rd(10'h188, rv); chk("R10 status clear", rv, 0);

        // R7 zero width counts as one
        sync_run(2'b11, 0, 0, 0, 8);
        chk("R7 width0", r_highs, 1);

        // R8 periodic
        sync_run(2'b11, 2, 5, 0, 20);
        chk("R8 rises", r_rises, 4);
        chk("R8 highs", r_highs, 8);
        // R6 disable stops output
        wr(10'h180, 32'h0);
        run_cycles(10);
        chk("R6 off", r_highs, 0);

        // R8 period not above width: continuous
        sync_run(2'b11, 3, 2, 0, 12);
        chk("R8 continuous highs", r_highs, 12);
        chk("R8 continuous rises", r_rises, 1);
        wr(10'h180, 32'h0);

        // R9 start delay
        sync_run(2'b11, 1, 0, 4, 12);
        chk("R9 first rise", r_first, 5);
        chk("R9 highs", r_highs, 1);

        // R6 partial enable ignores trigger
        sync_run(2'b01, 2, 0, 0, 8);
        chk("R6 partial", r_highs, 0);
        rd(10'h188, rv); chk("R6 no status", rv, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule